// File: doc/BRIEF.md
# Programmable Lifting Multiply-Accumulate Pair

This block holds the two arithmetic elements that carry out one regularised lifting step of a wavelet or wavelet-packet transform. The data arrives as a stream of coefficient pairs (a, b), where a is the even sample and b is the odd sample. The first element (the s unit) rewrites the even sample using odd samples. The second element (the t unit) rewrites the odd sample using even samples, and it looks one pair ahead. Each unit multiplies a 16-bit sample by a signed Q2.13 coefficient, accumulates at full precision, then rounds and saturates the result back to 16 bits.

A 3-bit opcode is supplied with every operation and selects one of five step forms: a single tap on the current neighbour, a single tap on the delayed or look-ahead neighbour, a second accumulation pass for two-tap polynomials, a symmetric two-neighbour tap, and scaling. An inverse flag turns the adds into subtracts so that the same opcodes undo a step. A swap flag exchanges the two inputs before the operation, which lets a permutation step run without moving data in memory. A start flag marks the first pair of a block. Samples outside the block count as zero. The surrounding memory and the sequencer drive both units and write their results back in place. The two units have independent ports, so the sequencer decides whether one feeds the other.

Top module: `lift_mac_pair`

## Requirements
- R1: Opcode encoding: 0 = single tap on the current neighbour, 1 = single tap on the delayed/look-ahead neighbour, 2 = accumulate a second tap, 3 = symmetric tap, 4 = scale. Coefficients are signed Q2.13. The s unit result is a + c0·b (op 0), a + c1·d (op 1), A + c1·d (op 2), a + c0·(b + d) (op 3) or c0·a (op 4). Here d is the delayed odd sample and A is the unrounded result of the previous operation. Results are rounded by adding one half LSB and then flooring.
- R2: The s unit presents its result on out_a and the unchanged (post-swap) b on out_b, with out_valid high in the cycle after the second rising edge that follows an accepted input.
- R3: The s delay register captures b on every accepted operation except op 0. When start accompanies a pair, the delay reads as zero for that operation and stays zero if the operation is op 0.
- R4: Op 0 followed by op 2 on the same pair yields a + c0·b + c1·d with a single rounding at the end.
- R5: Op 3 applies one coefficient to the sum of the current and delayed neighbour.
- R6: With the inverse flag set, ops 0 to 3 subtract the product instead of adding it. Op 4 ignores the flag.
- R7: Results above 32767 or below -32768 clamp to those limits.
- R8: The swap flag exchanges the a and b inputs before the operation, in both units.
- R9: The t unit holds the previous pair. An accepted operation retires that held pair: out_a is the held a, and out_b is the held b updated by the opcode using the incoming a as the look-ahead neighbour. If no pair is held, nothing is emitted. The latency matches that of R2.
- R10: When start accompanies the incoming pair, the t unit uses zero as the look-ahead for the pair it retires and then holds the incoming pair as the first of the new block.
- R11: In the t unit, op 0 emits the partial result b + c0·a for the held pair and keeps that pair held. A following op 2 adds c1 times the incoming a to it and advances.
- R12: After reset both out_valid outputs are low, the s delay reads zero, and the t unit holds no pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_in_valid | input | 1 | s unit operation strobe |
| s_start | input | 1 | s unit first pair of a block |
| s_op | input | 3 | s unit opcode |
| s_inv | input | 1 | s unit inverse (subtract) |
| s_swap | input | 1 | s unit exchange inputs |
| s_c0 | input | 16 | s unit coefficient for current neighbour / scale |
| s_c1 | input | 16 | s unit coefficient for delayed neighbour |
| s_a | input | 16 | s unit even sample in |
| s_b | input | 16 | s unit odd sample in |
| s_out_valid | output | 1 | s unit result strobe |
| s_out_a | output | 16 | s unit updated even sample |
| s_out_b | output | 16 | s unit odd sample passed on |
| t_in_valid | input | 1 | t unit operation strobe |
| t_start | input | 1 | t unit first pair of a block |
| t_op | input | 3 | t unit opcode |
| t_inv | input | 1 | t unit inverse (subtract) |
| t_swap | input | 1 | t unit exchange inputs |
| t_c0 | input | 16 | t unit coefficient for current neighbour / scale |
| t_c1 | input | 16 | t unit coefficient for look-ahead neighbour |
| t_a | input | 16 | t unit even sample in |
| t_b | input | 16 | t unit odd sample in |
| t_out_valid | output | 1 | t unit result strobe |
| t_out_a | output | 16 | t unit even sample passed on |
| t_out_b | output | 16 | t unit updated odd sample |

## Verification
Every cycle, the assertions check the two-edge latency of both units and the absence of spurious results. They also check that the odd sample passes through the s unit unchanged and the held even sample passes through the t unit, that the t unit stays silent when it holds no pair, and that op 0 leaves the s delay register and the t held pair untouched. The arithmetic itself can only be shown by the bench's scenarios. This covers the rounding of halves, saturation at both limits, the single rounding across a two-pass accumulation, the inverse and swap variants, and the zero neighbours at block starts and after reset.

// File: rtl/lift_pkg.sv
`timescale 1ns/1ps
package lift_pkg;

  typedef enum logic [2:0] {
    OP_TAP0  = 3'd0,
    OP_TAP1  = 3'd1,
    OP_ACC1  = 3'd2,
    OP_SYM   = 3'd3,
    OP_SCALE = 3'd4
  } lift_op_e;

endpackage

// File: rtl/lift_mac_core.sv
`timescale 1ns/1ps
// Combinational multiply-add shared by both units.
// base : sample being rewritten (also the operand of scaling)
// near : neighbour of the same index
// far  : delayed (s) or look-ahead (t) neighbour
module lift_mac_core
  import lift_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FW = 13,
  localparam int AW = CW + DW + 3
) (
  input  lift_op_e              op,
  input  logic                  inv,
  input  logic signed [DW-1:0]  base,
  input  logic signed [DW-1:0]  near,
  input  logic signed [DW-1:0]  far,
  input  logic signed [CW-1:0]  c0,
  input  logic signed [CW-1:0]  c1,
  input  logic signed [AW-1:0]  acc_prev,
  output logic signed [AW-1:0]  sum
);
  localparam int PW = CW + DW + 1;

  function automatic logic signed [DW:0] ext1(input logic signed [DW-1:0] v);
    return {v[DW-1], v};
  endfunction

  function automatic logic signed [AW-1:0] to_q(input logic signed [DW-1:0] v);
    return AW'(v) <<< FW;
  endfunction

  logic signed [CW-1:0] c_sel;
  logic signed [DW:0]   x_sel;
  logic signed [AW-1:0] seed;
  logic                 use_neg;
  logic signed [PW-1:0] prod;

  always_comb begin
    c_sel   = c0;
    x_sel   = ext1(near);
    seed    = to_q(base);
    use_neg = inv;
    case (op)
      OP_TAP1: begin
        c_sel = c1;
        x_sel = ext1(far);
      end
      OP_ACC1: begin
        c_sel = c1;
        x_sel = ext1(far);
        seed  = acc_prev;
      end
      OP_SYM: x_sel = ext1(near) + ext1(far);
      OP_SCALE: begin
        x_sel   = ext1(base);
        seed    = '0;
        use_neg = 1'b0;
      end
      default: ;
    endcase
    prod = PW'(c_sel) * PW'(x_sel);
    sum  = use_neg ? (seed - AW'(prod)) : (seed + AW'(prod));
  end

endmodule

// File: rtl/lift_rnd_stage.sv
`timescale 1ns/1ps
// Output register: round half up, saturate, and carry the untouched sample.
module lift_rnd_stage #(
  parameter int DW = 16,
  parameter int FW = 13,
  parameter int AW = 35
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [AW-1:0] wide,
  input  logic signed [DW-1:0] pass,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_res,
  output logic signed [DW-1:0] out_pass
);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FW - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DW - 1));

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [AW-1:0] w);
    logic signed [AW-1:0] r;
    r = (w + HALF) >>> FW;
    if (r > MAXV)      r = MAXV;
    else if (r < MINV) r = MINV;
    return $signed(r[DW-1:0]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_pass  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res  <= rnd_sat(wide);
        out_pass <= pass;
      end
    end
  end

endmodule

// File: rtl/lift_s_unit.sv
`timescale 1ns/1ps
// Even-sample updater: uses current and delayed odd samples.
module lift_s_unit
  import lift_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FW = 13,
  localparam int AW = CW + DW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 blk_start,
  input  lift_op_e             op,
  input  logic                 inv,
  input  logic                 swap,
  input  logic signed [CW-1:0] c0,
  input  logic signed [CW-1:0] c1,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b
);
  logic signed [DW-1:0] a_eff, b_eff, dly_q, dly_eff;
  logic signed [AW-1:0] sum, acc_q;
  logic signed [DW-1:0] pass_q;
  logic                 v1_q;
  logic                 dly_load, dly_clear;

  assign a_eff     = swap ? b : a;
  assign b_eff     = swap ? a : b;
  assign dly_eff   = blk_start ? '0 : dly_q;
  assign dly_load  = in_valid && (op != OP_TAP0);
  assign dly_clear = in_valid && blk_start && (op == OP_TAP0);

  lift_mac_core #(.DW(DW), .CW(CW), .FW(FW)) u_core (
    .op(op), .inv(inv), .base(a_eff), .near(b_eff), .far(dly_eff),
    .c0(c0), .c1(c1), .acc_prev(acc_q), .sum(sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      acc_q  <= '0;
      pass_q <= '0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        acc_q  <= sum;
        pass_q <= b_eff;
      end
      if (dly_load)       dly_q <= b_eff;
      else if (dly_clear) dly_q <= '0;
    end
  end

  lift_rnd_stage #(.DW(DW), .FW(FW), .AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(v1_q), .wide(acc_q), .pass(pass_q),
    .out_valid(out_valid), .out_res(out_a), .out_pass(out_b)
  );

  AST_S_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R2
  AST_S_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2)); // R2
  AST_S_PASS_B: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 (out_b == $past(b_eff, 2))); // R2
  AST_S_TAP0_KEEPS_DLY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !blk_start && op == OP_TAP0) |=> $stable(dly_q)); // R3

endmodule

// File: rtl/lift_t_unit.sv
`timescale 1ns/1ps
// Odd-sample updater: retires the held pair using the incoming even sample.
module lift_t_unit
  import lift_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FW = 13,
  localparam int AW = CW + DW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 blk_start,
  input  lift_op_e             op,
  input  logic                 inv,
  input  logic                 swap,
  input  logic signed [CW-1:0] c0,
  input  logic signed [CW-1:0] c1,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b
);
  logic signed [DW-1:0] a_eff, b_eff, look;
  logic signed [DW-1:0] ha_q, hb_q, pass_q;
  logic                 hv_q, v1_q;
  logic signed [AW-1:0] sum, acc_q;
  logic                 retire, capture;

  assign a_eff   = swap ? b : a;
  assign b_eff   = swap ? a : b;
  assign look    = blk_start ? '0 : a_eff;
  assign retire  = in_valid && hv_q;
  assign capture = in_valid && ((op != OP_TAP0) || blk_start || !hv_q);

  lift_mac_core #(.DW(DW), .CW(CW), .FW(FW)) u_core (
    .op(op), .inv(inv), .base(hb_q), .near(ha_q), .far(look),
    .c0(c0), .c1(c1), .acc_prev(acc_q), .sum(sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ha_q   <= '0;
      hb_q   <= '0;
      hv_q   <= 1'b0;
      acc_q  <= '0;
      pass_q <= '0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= retire;
      if (retire) begin
        acc_q  <= sum;
        pass_q <= ha_q;
      end
      if (capture) begin
        ha_q <= a_eff;
        hb_q <= b_eff;
        hv_q <= 1'b1;
      end
    end
  end

  lift_rnd_stage #(.DW(DW), .FW(FW), .AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(v1_q), .wide(acc_q), .pass(pass_q),
    .out_valid(out_valid), .out_res(out_b), .out_pass(out_a)
  );

  AST_T_SILENT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hv_q) |=> ##1 !out_valid); // R9
  AST_T_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2)); // R9
  AST_T_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hv_q) |=> ##1 (out_a == $past(ha_q, 2))); // R9
  AST_T_TAP0_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hv_q && !blk_start && op == OP_TAP0) |=> ($stable(ha_q) && $stable(hb_q))); // R11

endmodule

// File: rtl/lift_mac_pair.sv
`timescale 1ns/1ps
module lift_mac_pair
  import lift_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FW = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_in_valid,
  input  logic                 s_start,
  input  logic [2:0]           s_op,
  input  logic                 s_inv,
  input  logic                 s_swap,
  input  logic signed [CW-1:0] s_c0,
  input  logic signed [CW-1:0] s_c1,
  input  logic signed [DW-1:0] s_a,
  input  logic signed [DW-1:0] s_b,
  output logic                 s_out_valid,
  output logic signed [DW-1:0] s_out_a,
  output logic signed [DW-1:0] s_out_b,
  input  logic                 t_in_valid,
  input  logic                 t_start,
  input  logic [2:0]           t_op,
  input  logic                 t_inv,
  input  logic                 t_swap,
  input  logic signed [CW-1:0] t_c0,
  input  logic signed [CW-1:0] t_c1,
  input  logic signed [DW-1:0] t_a,
  input  logic signed [DW-1:0] t_b,
  output logic                 t_out_valid,
  output logic signed [DW-1:0] t_out_a,
  output logic signed [DW-1:0] t_out_b
);

  lift_s_unit #(.DW(DW), .CW(CW), .FW(FW)) u_s (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .blk_start(s_start),
    .op(lift_op_e'(s_op)), .inv(s_inv), .swap(s_swap), .c0(s_c0), .c1(s_c1),
    .a(s_a), .b(s_b), .out_valid(s_out_valid), .out_a(s_out_a), .out_b(s_out_b)
  );

  lift_t_unit #(.DW(DW), .CW(CW), .FW(FW)) u_t (
    .clk(clk), .rst_n(rst_n), .in_valid(t_in_valid), .blk_start(t_start),
    .op(lift_op_e'(t_op)), .inv(t_inv), .swap(t_swap), .c0(t_c0), .c1(t_c1),
    .a(t_a), .b(t_b), .out_valid(t_out_valid), .out_a(t_out_a), .out_b(t_out_b)
  );

endmodule

// File: tb/tb_lift_mac_pair.sv
`timescale 1ns/1ps
module tb_lift_mac_pair;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_in_valid = 0, s_start = 0, s_inv = 0, s_swap = 0;
  logic [2:0] s_op = '0;
  logic signed [15:0] s_c0 = '0, s_c1 = '0, s_a = '0, s_b = '0;
  logic s_out_valid;
  logic signed [15:0] s_out_a, s_out_b;
  logic t_in_valid = 0, t_start = 0, t_inv = 0, t_swap = 0;
  logic [2:0] t_op = '0;
  logic signed [15:0] t_c0 = '0, t_c1 = '0, t_a = '0, t_b = '0;
  logic t_out_valid;
  logic signed [15:0] t_out_a, t_out_b;

  lift_mac_pair dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // floor((w + half) / 2^13) by modular arithmetic, then clamp
  function automatic longint q_round(input longint w);
    longint r, m;
    r = w + 4096;
    m = ((r % 8192) + 8192) % 8192;
    r = (r - m) / 8192;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // reference state
  longint m_dly = 0, m_sacc = 0, m_ha = 0, m_hb = 0, m_tacc = 0;
  bit     m_hv = 0;

  function automatic longint lift_ref(input int op, input bit inv, input longint base,
      input longint near, input longint far, input longint c0, input longint c1,
      input longint prev);
    longint sg;
    sg = inv ? -1 : 1;
    case (op)
      0: return base * 8192 + sg * c0 * near;
      1: return base * 8192 + sg * c1 * far;
      2: return prev + sg * c1 * far;
      3: return base * 8192 + sg * c0 * (near + far);
      default: return c0 * base;
    endcase
  endfunction

  task automatic s_apply(input int op, input bit inv, input bit sw, input bit st,
      input longint a, input longint b, input longint c0, input longint c1, input string req);
    longint ea, eb, d, w;
    ea = sw ? b : a;
    eb = sw ? a : b;
    d  = st ? 0 : m_dly;
    w  = lift_ref(op, inv, ea, eb, d, c0, c1, m_sacc);
    m_sacc = w;
    if (op != 0) m_dly = eb; else if (st) m_dly = 0;
    @(negedge clk);
    s_op = op[2:0]; s_inv = inv; s_swap = sw; s_start = st;
    s_a = a[15:0]; s_b = b[15:0]; s_c0 = c0[15:0]; s_c1 = c1[15:0]; s_in_valid = 1;
    @(negedge clk);
    s_in_valid = 0; s_start = 0;
    @(negedge clk);
    chk(s_out_valid == 1'b1, "R2", "s_out_valid", longint'(s_out_valid), 1);
    chk(longint'(s_out_a) == q_round(w), req, "s_out_a", longint'(s_out_a), q_round(w));
    chk(longint'(s_out_b) == eb, "R2", "s_out_b", longint'(s_out_b), eb);
  endtask

  task automatic t_apply(input int op, input bit inv, input bit sw, input bit st,
      input longint a, input longint b, input longint c0, input longint c1, input string req);
    longint ea, eb, la, w, exp_a;
    bit emit;
    ea = sw ? b : a;
    eb = sw ? a : b;
    la = st ? 0 : ea;
    emit = m_hv;
    w = lift_ref(op, inv, m_hb, m_ha, la, c0, c1, m_tacc);
    exp_a = m_ha;
    if (emit) m_tacc = w;
    if (op != 0 || st || !m_hv) begin
      m_ha = ea; m_hb = eb; m_hv = 1;
    end
    @(negedge clk);
    t_op = op[2:0]; t_inv = inv; t_swap = sw; t_start = st;
    t_a = a[15:0]; t_b = b[15:0]; t_c0 = c0[15:0]; t_c1 = c1[15:0]; t_in_valid = 1;
    @(negedge clk);
    t_in_valid = 0; t_start = 0;
    @(negedge clk);
    chk(t_out_valid == emit, req, "t_out_valid", longint'(t_out_valid), longint'(emit));
    if (emit) begin
      chk(longint'(t_out_a) == exp_a, req, "t_out_a", longint'(t_out_a), exp_a);
      chk(longint'(t_out_b) == q_round(w), req, "t_out_b", longint'(t_out_b), q_round(w));
    end
  endtask

  typedef struct packed {
    logic [2:0]         op;
    logic               inv;
    logic               swap;
    logic               start;
    logic signed [15:0] a;
    logic signed [15:0] b;
    logic signed [15:0] c0;
    logic signed [15:0] c1;
    logic [3:0]         req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t S_VEC [NV] = '{
    '{3'd0, 1'b0, 1'b0, 1'b1, 16'sd1000,   16'sd200,   16'sd4096,  16'sd0,     4'd1}, // R1 tap on b
    '{3'd0, 1'b0, 1'b0, 1'b0, 16'sd0,      16'sd3,    -16'sd4096,  16'sd0,     4'd1}, // R1 -1.5 rounds to -1
    '{3'd1, 1'b0, 1'b0, 1'b0, -16'sd500,   16'sd300,  -16'sd2048, -16'sd2048,  4'd3}, // R3 op 0 left delay at zero
    '{3'd1, 1'b0, 1'b0, 1'b0, 16'sd100,   -16'sd7,     16'sd0,     16'sd8192,  4'd3}, // R3 delay holds 300
    '{3'd0, 1'b0, 1'b0, 1'b0, 16'sd10,     16'sd50,    16'sd4096,  16'sd0,     4'd4}, // R4 first pass
    '{3'd2, 1'b0, 1'b0, 1'b0, 16'sd10,     16'sd50,    16'sd0,     16'sd2048,  4'd4}, // R4 second pass, one rounding
    '{3'd3, 1'b0, 1'b0, 1'b0, 16'sd0,      16'sd1000, -16'sd3277,  16'sd0,     4'd5}, // R5 symmetric
    '{3'd0, 1'b1, 1'b0, 1'b0, 16'sd1000,   16'sd400,   16'sd8192,  16'sd0,     4'd6}, // R6 inverse subtracts
    '{3'd4, 1'b1, 1'b0, 1'b0, 16'sd3000,   16'sd9,     16'sd12000, 16'sd0,     4'd6}, // R6 scale ignores inverse
    '{3'd4, 1'b0, 1'b0, 1'b0, 16'sd30000,  16'sd0,     16'sd16383, 16'sd0,     4'd7}, // R7 positive clamp
    '{3'd0, 1'b1, 1'b0, 1'b0, -16'sd30000, 16'sd20000, 16'sd8192,  16'sd0,     4'd7}, // R7 negative clamp
    '{3'd0, 1'b0, 1'b1, 1'b0, 16'sd5,      16'sd1000,  16'sd4096,  16'sd0,     4'd8}, // R8 swapped inputs
    '{3'd3, 1'b0, 1'b0, 1'b1, 16'sd100,    16'sd10,    16'sd8192,  16'sd0,     4'd3}, // R3 start zeroes delay
    '{3'd1, 1'b1, 1'b0, 1'b0, 16'sd50,     16'sd77,    16'sd0,     16'sd8192,  4'd6}  // R6 inverse on delayed tap
  };

  initial begin
    // R12: reset state
    repeat (2) @(negedge clk);
    chk(s_out_valid == 1'b0, "R12", "s_out_valid in reset", longint'(s_out_valid), 0);
    chk(t_out_valid == 1'b0, "R12", "t_out_valid in reset", longint'(t_out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_out_valid == 1'b0, "R12", "s_out_valid after reset", longint'(s_out_valid), 0);

    for (int i = 0; i < NV; i++) begin
      s_apply(int'(S_VEC[i].op), S_VEC[i].inv, S_VEC[i].swap, S_VEC[i].start,
              longint'(S_VEC[i].a), longint'(S_VEC[i].b),
              longint'(S_VEC[i].c0), longint'(S_VEC[i].c1),
              $sformatf("R%0d", S_VEC[i].req));
    end

    // t unit directed
    t_apply(1, 0, 0, 1, 10, 20, 0, 4096, "R9");       // first pair: nothing emitted
    t_apply(1, 0, 0, 0, 30, 40, 0, 4096, "R9");       // retire (10,20) with look-ahead 30
    t_apply(0, 0, 0, 0, 999, 999, 8192, 0, "R11");    // partial, pair kept
    t_apply(2, 0, 0, 0, 5, 6, 0, -8192, "R11");       // finish with look-ahead 5
    t_apply(3, 0, 0, 1, 100, 200, 4096, 0, "R10");    // boundary: look-ahead zero
    t_apply(4, 1, 0, 0, 1, 2, -8192, 0, "R1");        // scale of held odd sample
    t_apply(1, 1, 1, 0, 7, 50, 0, 8192, "R8");        // swap + inverse
    t_apply(3, 0, 0, 0, -32768, 32767, 16383, 0, "R7"); // clamp in t unit

    // mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    m_dly = 0; m_sacc = 0; m_ha = 0; m_hb = 0; m_tacc = 0; m_hv = 0;
    @(negedge clk);
    chk(s_out_valid == 1'b0, "R12", "s_out_valid mid reset", longint'(s_out_valid), 0);
    rst_n = 1'b1;
    s_apply(1, 0, 0, 0, 0, 5, 0, 8192, "R12");        // delay reads zero after reset
    t_apply(1, 0, 0, 0, 3, 4, 0, 8192, "R12");        // no held pair after reset

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule